// File: doc/BRIEF.md
# Carrier Tracking Mode Sequencer

This block is the mode controller for a receiver carrier tracking loop. After an acquire pulse it always closes the loop in frequency-lock mode at its widest bandwidth. It then narrows the bandwidth one step at a time, hands over to a wideband phase-lock mode, and comes to rest in a narrow phase-lock mode. The loop filter, the NCO and the lock detector sit outside the block. They read its mode select, its bandwidth-step index and its predetection integration length.

Each step lasts a programmable number of epoch strobes. If the phase lock detector reports loss of lock on an epoch while either phase-lock mode is active, the sequencer drops back to the widest frequency-lock step and runs the whole pull-in again. While a phase-lock mode is active, the block samples the data-bit inversion flag on each epoch. It raises a flag telling the consumer to add half a cycle to the reported carrier phase. This resolves the half-cycle ambiguity of a Costas loop.

Top module: `carrier_mode_seq`

## Requirements
- R1: On synchronous active-low reset, mode_o is 00 (idle), bw_idx_o is 0, pdi_ms_o is 0 and flip_o is 0.
- R2: A cycle with start_i high, in any state, puts the block in frequency-lock mode (mode_o 01) at bw_idx_o 0 on the next cycle. Idle only ever leaves to frequency-lock mode.
- R3: In frequency-lock mode, bw_idx_o rises by one after hold_i epoch strobes, and a hold_i of 0 counts as 1. Leaving the last frequency-lock step (index FLL_STEPS-1) enters wideband phase-lock mode (mode_o 10) with bw_idx_o equal to FLL_STEPS.
- R4: Wideband phase-lock mode lasts hold_i epochs. It then enters narrow phase-lock mode (mode_o 11) with bw_idx_o equal to FLL_STEPS+1, which stays put while lock holds.
- R5: In either phase-lock mode, an epoch with lock_i low returns the block to frequency-lock mode at bw_idx_o 0 on the next cycle. lock_i is ignored in frequency-lock mode and on cycles without an epoch.
- R6: pdi_ms_o depends on the mode. In frequency-lock mode it is 1 when dwell_2ms_i is 0 and 2 when dwell_2ms_i is 1. In wideband phase-lock mode it is PDI_WIDE (5), in narrow phase-lock mode it is PDI_NARROW (20), and in idle it is 0.
- R7: On an epoch in either phase-lock mode, with lock held, flip_o takes the value of inv_i on the next cycle and keeps it until the next such epoch. flip_o is 0 in idle and in frequency-lock mode.
- R8: Only epoch strobes advance the hold count. With no epoch and no start, mode_o and bw_idx_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Acquire pulse, restarts pull-in |
| epoch_i | input | 1 | Integration epoch strobe |
| lock_i | input | 1 | Phase lock detector flag, 1 = locked |
| inv_i | input | 1 | Data bit phase inverted |
| dwell_2ms_i | input | 1 | Search dwell: 0 = 1 ms, 1 = 2 ms |
| hold_i | input | HOLD_W (8) | Epochs per bandwidth step |
| mode_o | output | 2 | 00 idle, 01 FLL, 10 wide PLL, 11 narrow PLL |
| bw_idx_o | output | IDX_W (3) | Bandwidth step index, 0 = widest |
| pdi_ms_o | output | PDI_W (5) | Predetection integration length in ms |
| flip_o | output | 1 | Add 180 degrees to reported carrier phase |

## Verification
The pull-in is first walked with a step hold of two epochs. Idle cycles are placed between epochs so that counting epochs can be told apart from counting clocks. A low lock flag is applied during frequency-lock mode and on non-epoch cycles, which separates these ignored cases from a real loss of lock on an epoch in a phase-lock mode. The inversion flag toggles across phase-lock epochs and also during frequency-lock mode, which shows that the correction follows only sampled phase-lock epochs. Directed runs use a hold of zero, the 2 ms dwell, a restart from narrow phase lock and a mid-run reset.

// File: rtl/cms_pkg.sv
// Shared types for the carrier tracking mode sequencer.
package cms_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_FLL  = 2'b01,
        MODE_WPLL = 2'b10,
        MODE_NPLL = 2'b11
    } mode_t;
endpackage

// File: rtl/cms_epoch_timer.sv
// Counts epoch strobes within one bandwidth step.
// It pulses expire_o on the epoch that completes hold_i epochs, and treats a hold of 0 as 1.
// Assumes clear_i and epoch_i are single-cycle qualified strobes.
module cms_epoch_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              epoch_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              expire_o
);
    logic [HOLD_W-1:0] cnt_q;
    logic [HOLD_W-1:0] last_cnt;

    // Index of the epoch that closes a step.
    always_comb begin
        last_cnt = (hold_i == '0) ? '0 : hold_i - 1'b1;
    end

    assign expire_o = epoch_i && !clear_i && (cnt_q >= last_cnt);

    // Epoch counter, cleared on restart or on step completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (epoch_i) begin
            cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cms_mode_fsm.sv
// Mode and bandwidth-step state machine.
// Starts in FLL at step 0, walks FLL_STEPS steps, then wide PLL, then narrow PLL.
// Loss of lock on an epoch in either PLL mode restarts at FLL step 0.
// Assumes expire_i comes from a timer cleared by clear_o.
module cms_mode_fsm
    import cms_pkg::*;
#(
    parameter int FLL_STEPS = 3,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             epoch_i,
    input  logic             lock_i,
    input  logic             expire_i,
    output mode_t            mode_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             is_pll_o,
    output logic             clear_o
);
    localparam logic [IDX_W-1:0] FLL_LAST = IDX_W'(FLL_STEPS - 1);

    mode_t            mode_q, mode_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             lock_lost;

    assign is_pll_o  = (mode_q == MODE_WPLL) || (mode_q == MODE_NPLL);
    assign lock_lost = epoch_i && !lock_i && is_pll_o;
    assign clear_o   = start_i || lock_lost;

    // Next-state selection: start, then lock loss, then step advance.
    always_comb begin
        mode_d = mode_q;
        idx_d  = idx_q;
        if (clear_o) begin
            mode_d = MODE_FLL;
            idx_d  = '0;
        end else if (expire_i) begin
            case (mode_q)
                MODE_FLL: begin
                    idx_d = idx_q + 1'b1;
                    if (idx_q == FLL_LAST) begin
                        mode_d = MODE_WPLL;
                    end
                end
                MODE_WPLL: begin
                    mode_d = MODE_NPLL;
                    idx_d  = idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_IDLE;
            idx_q  <= '0;
        end else begin
            mode_q <= mode_d;
            idx_q  <= idx_d;
        end
    end

    assign mode_o = mode_q;
    assign idx_o  = idx_q;
endmodule

// File: rtl/cms_phase_fix.sv
// Half-cycle correction flag for the reported carrier phase.
// It follows the sampled data-bit inversion and is forced to 0 on restart.
// Assumes sample_i is raised only on epochs in a PLL mode.
module cms_phase_fix (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic sample_i,
    input  logic inv_i,
    output logic flip_o
);
    // Flag register: clear on restart, update on a sampled epoch.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            flip_o <= 1'b0;
        end else if (sample_i) begin
            flip_o <= inv_i;
        end
    end
endmodule

// File: rtl/carrier_mode_seq.sv
// Carrier tracking mode sequencer top.
// Runs FLL-first staged pull-in into narrow PLL, falls back on loss of lock,
// and flags the 180 degree phase correction.
// Assumes single-cycle start and epoch strobes synchronous to clk.
module carrier_mode_seq
    import cms_pkg::*;
#(
    parameter int FLL_STEPS  = 3,
    parameter int HOLD_W     = 8,
    parameter int PDI_W      = 5,
    parameter int PDI_WIDE   = 5,
    parameter int PDI_NARROW = 20,
    parameter int IDX_W      = $clog2(FLL_STEPS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              epoch_i,
    input  logic              lock_i,
    input  logic              inv_i,
    input  logic              dwell_2ms_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic [1:0]        mode_o,
    output logic [IDX_W-1:0]  bw_idx_o,
    output logic [PDI_W-1:0]  pdi_ms_o,
    output logic              flip_o
);
    mode_t mode;
    logic  is_pll;
    logic  clear;
    logic  expire;

    cms_epoch_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .epoch_i  (epoch_i),
        .hold_i   (hold_i),
        .expire_o (expire)
    );

    cms_mode_fsm #(.FLL_STEPS(FLL_STEPS), .IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .epoch_i  (epoch_i),
        .lock_i   (lock_i),
        .expire_i (expire),
        .mode_o   (mode),
        .idx_o    (bw_idx_o),
        .is_pll_o (is_pll),
        .clear_o  (clear)
    );

    cms_phase_fix u_fix (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .sample_i (epoch_i && is_pll),
        .inv_i    (inv_i),
        .flip_o   (flip_o)
    );

    assign mode_o = mode;

    // Integration length per mode.
    always_comb begin
        case (mode)
            MODE_FLL:  pdi_ms_o = dwell_2ms_i ? PDI_W'(2) : PDI_W'(1);
            MODE_WPLL: pdi_ms_o = PDI_W'(PDI_WIDE);
            MODE_NPLL: pdi_ms_o = PDI_W'(PDI_NARROW);
            default:   pdi_ms_o = '0;
        endcase
    end
endmodule

// File: rtl/cms_checker.sv
// Protocol checks for carrier_mode_seq, attached by bind.
module cms_checker #(
    parameter int FLL_STEPS  = 3,
    parameter int HOLD_W     = 8,
    parameter int PDI_W      = 5,
    parameter int PDI_WIDE   = 5,
    parameter int PDI_NARROW = 20,
    parameter int IDX_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              epoch_i,
    input logic              lock_i,
    input logic              inv_i,
    input logic              dwell_2ms_i,
    input logic [HOLD_W-1:0] hold_i,
    input logic [1:0]        mode_o,
    input logic [IDX_W-1:0]  bw_idx_o,
    input logic [PDI_W-1:0]  pdi_ms_o,
    input logic              flip_o
);
    logic pll;
    assign pll = mode_o[1];

    assert_start_fll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (mode_o == 2'b01) && (bw_idx_o == '0));

    assert_idle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |=> (mode_o == 2'b00) || (mode_o == 2'b01));

    assert_narrow_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11) && !start_i && !(epoch_i && !lock_i) |=> (mode_o == 2'b11));

    assert_fallback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pll && epoch_i && !lock_i |=> (mode_o == 2'b01) && (bw_idx_o == '0));

    assert_pdi_fll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01) |-> (pdi_ms_o == (dwell_2ms_i ? PDI_W'(2) : PDI_W'(1))));

    assert_flip_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pll |-> !flip_o);

    assert_flip_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pll && epoch_i && lock_i && !start_i |=> flip_o == $past(inv_i));

    assert_epoch_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !epoch_i && !start_i |=> $stable(mode_o) && $stable(bw_idx_o));
endmodule

bind carrier_mode_seq cms_checker #(
    .FLL_STEPS (FLL_STEPS),
    .HOLD_W    (HOLD_W),
    .PDI_W     (PDI_W),
    .PDI_WIDE  (PDI_WIDE),
    .PDI_NARROW(PDI_NARROW),
    .IDX_W     (IDX_W)
) u_chk (.*);

// File: tb/carrier_mode_seq_tb.sv
// Testbench: vector table walked against a requirement model, then directed cases.
module carrier_mode_seq_tb;
    localparam int FLL_STEPS = 3;
    localparam int HOLD_W    = 8;
    localparam int PDI_W     = 5;
    localparam int IDX_W     = 3;

    // Vector bits: {start, epoch, lock, inv}
    localparam int NVEC = 20;
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1000, 4'b0100, 4'b0000, 4'b0110, 4'b0100,
        4'b0100, 4'b0101, 4'b0111, 4'b0111, 4'b0001,
        4'b0110, 4'b0111, 4'b0010, 4'b0110, 4'b0111,
        4'b0100, 4'b0110, 4'b0110, 4'b1000, 4'b0110
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, epoch_i = 1'b0, lock_i = 1'b0, inv_i = 1'b0;
    logic dwell_2ms_i = 1'b0;
    logic [HOLD_W-1:0] hold_i = 8'd2;
    logic [1:0]       mode_o;
    logic [IDX_W-1:0] bw_idx_o;
    logic [PDI_W-1:0] pdi_ms_o;
    logic             flip_o;

    int nchk = 0;
    int nbad = 0;
    logic done = 1'b0;

    // Model state
    logic [1:0] m_mode;
    int m_idx, m_cnt;
    logic m_flip;

    always #5 clk = ~clk;

    carrier_mode_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .epoch_i(epoch_i),
        .lock_i(lock_i), .inv_i(inv_i), .dwell_2ms_i(dwell_2ms_i), .hold_i(hold_i),
        .mode_o(mode_o), .bw_idx_o(bw_idx_o), .pdi_ms_o(pdi_ms_o), .flip_o(flip_o)
    );

    task automatic model_reset();
        m_mode = 2'b00; m_idx = 0; m_cnt = 0; m_flip = 1'b0;
    endtask

    // One clock of the requirement model.
    task automatic model_step(input logic [3:0] v);
        int lim;
        logic pll;
        lim = (hold_i == 0) ? 1 : int'(hold_i);
        pll = m_mode[1];
        if (v[3] || (v[2] && !v[1] && pll)) begin
            m_mode = 2'b01; m_idx = 0; m_cnt = 0; m_flip = 1'b0;
        end else if (v[2]) begin
            if (pll) m_flip = v[0];
            if (m_cnt + 1 >= lim) begin
                m_cnt = 0;
                if (m_mode == 2'b01) begin
                    m_idx = m_idx + 1;
                    if (m_idx == FLL_STEPS) m_mode = 2'b10;
                end else if (m_mode == 2'b10) begin
                    m_mode = 2'b11; m_idx = m_idx + 1;
                end
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    endtask

    function automatic int exp_pdi();
        case (m_mode)
            2'b01:   return dwell_2ms_i ? 2 : 1;
            2'b10:   return 5;
            2'b11:   return 20;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic compare(input string rm, input string rp, input string rf);
        check(rm, "mode", int'(mode_o), int'(m_mode));
        check(rm, "bw_idx", int'(bw_idx_o), m_idx);
        check(rp, "pdi", int'(pdi_ms_o), exp_pdi());
        check(rf, "flip", int'(flip_o), int'(m_flip));
    endtask

    // Drive one vector at negedge, step model at posedge, compare at next negedge.
    task automatic apply(input logic [3:0] v, input string rm);
        {start_i, epoch_i, lock_i, inv_i} = v;
        @(posedge clk);
        model_step(v);
        @(negedge clk);
        {start_i, epoch_i, lock_i, inv_i} = 4'b0000;
        compare(rm, "R6", "R7");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        compare("R1", "R1", "R1");

        // Table walk: R2 R3 R4 R5 R7 R8 with hold of two epochs
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i], (VEC[i][3]) ? "R2" : (m_mode[1] ? "R5" : "R3"));
        end

        // R3: hold of zero advances every epoch; R6 with 2 ms dwell
        hold_i = '0;
        dwell_2ms_i = 1'b1;
        apply(4'b1000, "R2");
        check("R6", "pdi 2ms", int'(pdi_ms_o), 2);
        apply(4'b0110, "R3");
        apply(4'b0110, "R3");
        apply(4'b0110, "R3");
        check("R3", "wide pll idx", int'(bw_idx_o), FLL_STEPS);
        check("R6", "pdi wide", int'(pdi_ms_o), 5);
        apply(4'b0111, "R4");
        check("R4", "narrow mode", int'(mode_o), 3);
        check("R6", "pdi narrow", int'(pdi_ms_o), 20);
        check("R7", "flip from wide epoch", int'(flip_o), 1);
        // R4: narrow PLL stays through further locked epochs
        apply(4'b0110, "R4");
        apply(4'b0110, "R4");
        check("R4", "narrow rest", int'(mode_o), 3);
        // R8: no epoch, lock low, nothing moves
        apply(4'b0000, "R8");
        check("R8", "stable mode", int'(mode_o), 3);
        // R2: restart from narrow PLL
        apply(4'b1111, "R2");
        check("R2", "restart mode", int'(mode_o), 1);

        // R1: mid-run reset
        apply(4'b0110, "R3");
        rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1", "R1", "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule